// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a shared system timer whose compare channels can also police software. A prescaler divides the system clock down to a slow tick (1 MHz in normal use). A free-running up-counter advances on each tick and wraps to zero after its top value. Each compare channel holds a match value. It sets a sticky status bit on the tick where the counter becomes equal to that value. One channel, chosen by a parameter, is the watchdog channel. When it matches while both its interrupt-enable bit and the separate watchdog-enable bit are set, the block drives a reset pulse of fixed length.

Software never reloads the counter. It writes the snapshot trigger, reads the frozen copy of the counter, adds the timeout in ticks and writes the sum into the watchdog match register. At a 1 MHz tick, timeouts from 30 s to 600 s fit easily in a 32-bit match value. Time left is the match value minus the counter, taken modulo the counter range.

The reset pulse comes from a small state machine with three named states:
- `WD_IDLE` moves to `WD_FIRE` when the watchdog channel hits while armed.
- `WD_FIRE` drives the reset output and moves to `WD_SPENT` after its last pulse cycle.
- `WD_SPENT` moves back to `WD_IDLE` only when software writes the watchdog match register.

The register bus has one cycle per write. Read data is combinational from the address.

Top module: `mtimer_wdog`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `wdog_rst` is low, so the watchdog starts disarmed.
- R2: The counter, read at offset 0x00 and zero-extended to 32 bits, advances by exactly one every CLK_HZ/TICK_HZ clock cycles. Writes to offset 0x00 have no effect.
- R3: The counter wraps from its all-ones value to 0 and keeps counting. A match value just past the wrap point is still detected.
- R4: A write to offset 0x30 with data bit 0 set copies the current counter into the snapshot register, which reads at 0x34. The snapshot holds while the counter moves on. A write to 0x30 with bit 0 clear leaves the snapshot unchanged.
- R5: The match register of channel i is at offset 0x08 + 4·i. Status bit i (register 0x20) becomes set on the clock edge where the counter takes the value held in match register i.
- R6: Status bits are sticky. Writing 1 to a bit of 0x20 clears that bit, and writing 0 leaves it unchanged. `irq` is high exactly when some status bit has its enable bit set in register 0x24. A channel whose enable bit is clear still sets its status bit but does not raise `irq`.
- R7: A reset pulse starts only if, when the watchdog channel (WD_CH) hits, both bit WD_CH of 0x24 and bit 0 of 0x28 are set. If either is clear, no pulse starts. This includes the case where 0x28 is cleared after the match register was written.
- R8: `wdog_rst` rises on the same edge that sets the watchdog status bit and stays high for exactly RST_CYC clock cycles.
- R9: After a pulse, `wdog_rst` does not fire again, even when the counter wraps around to the same match value, until the watchdog match register is written again.
- R10: Offsets with no register (for example 0x04, 0x2C, 0x38, 0x3C) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR over channels of status AND enable |
| wdog_rst | output | 1 | Watchdog reset pulse, RST_CYC cycles long |

## Verification
The bench builds the block with CLK_HZ=2 and TICK_HZ=1, so the counter ticks every other cycle. CNT_W=12 lets a full wrap of the counter happen in about 8k cycles. This makes both the wrap-crossing match and the "no second pulse after a full lap" case reachable in a short run. With RST_CYC=4 and all six channels present, the bench sweeps every channel over several small match distances and computes the expected match value and counter value arithmetically modulo 4096.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_COUNT   = 8'h00;
    localparam logic [AW-1:0] OFS_MATCH0  = 8'h08;
    localparam logic [AW-1:0] OFS_STATUS  = 8'h20;
    localparam logic [AW-1:0] OFS_INTEN   = 8'h24;
    localparam logic [AW-1:0] OFS_WDEN    = 8'h28;
    localparam logic [AW-1:0] OFS_SNAP    = 8'h30;
    localparam logic [AW-1:0] OFS_SNAPVAL = 8'h34;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_FIRE  = 2'd1,
        WD_SPENT = 2'd2
    } wd_state_e;

endpackage

// File: rtl/mtw_prescale.sv
module mtw_prescale #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)               div_q <= '0;
                else if (div_q == PW'(DIV - 1)) div_q <= '0;
                else                      div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/mtw_match_bank.sv
module mtw_match_bank #(
    parameter int N     = 6,
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           cnt_nxt,
    input  logic [N-1:0]               mwr,
    input  logic [CNT_W-1:0]           wdata,
    input  logic [N-1:0]               sts_clr,
    output logic [N-1:0][CNT_W-1:0]    match,
    output logic [N-1:0]               sts,
    output logic [N-1:0]               hit
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      match[g] <= '0;
                else if (mwr[g]) match[g] <= wdata;
            end

            // the hit fires on the edge where the counter takes the match value
            assign hit[g] = tick && (cnt_nxt == match[g]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          sts[g] <= 1'b0;
                else if (hit[g])     sts[g] <= 1'b1;
                else if (sts_clr[g]) sts[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/mtw_wd_fsm.sv
module mtw_wd_fsm
    import mtw_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic rearm,
    output logic wdog_rst
);
    localparam int PW = $clog2(RST_CYC + 1);

    wd_state_e      st_q, st_d;
    logic [PW-1:0]  pls_q;
    logic           last_cyc;

    assign last_cyc = (pls_q == PW'(RST_CYC - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_IDLE:  if (trig)     st_d = WD_FIRE;
            WD_FIRE:  if (last_cyc) st_d = WD_SPENT;
            WD_SPENT: if (rearm)    st_d = WD_IDLE;
            default:                st_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_IDLE;
            pls_q <= '0;
        end else begin
            st_q  <= st_d;
            pls_q <= (st_q == WD_FIRE && !last_cyc) ? pls_q + 1'b1 : '0;
        end
    end

    always_comb begin
        wdog_rst = (st_q == WD_FIRE);
    end
endmodule

// File: rtl/mtimer_wdog.sv
module mtimer_wdog
    import mtw_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1_000_000,
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 6,
    parameter int WD_CH   = 5,
    parameter int RST_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic          bus_we,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq,
    output logic          wdog_rst
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic                         tick;
    logic [CNT_W-1:0]             cnt_q, cnt_nxt, snap_q;
    logic [N_MATCH-1:0]           ie_q, sts, hit, mwr, sts_clr;
    logic [N_MATCH-1:0][CNT_W-1:0] match;
    logic                         wden_q;
    logic                         wr_sts, wr_ie, wr_wden, wr_snap;
    logic                         unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_sts  = bus_we && (bus_addr == OFS_STATUS);
    assign wr_ie   = bus_we && (bus_addr == OFS_INTEN);
    assign wr_wden = bus_we && (bus_addr == OFS_WDEN);
    assign wr_snap = bus_we && (bus_addr == OFS_SNAP);
    assign sts_clr = wr_sts ? bus_wdata[N_MATCH-1:0] : '0;

    generate
        for (genvar g = 0; g < N_MATCH; g++) begin : g_mwr
            assign mwr[g] = bus_we && (bus_addr == AW'(OFS_MATCH0 + 4 * g));
        end
    endgenerate

    mtw_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            snap_q <= '0;
            ie_q   <= '0;
            wden_q <= 1'b0;
        end else begin
            if (tick)                   cnt_q  <= cnt_nxt;
            if (wr_snap && bus_wdata[0]) snap_q <= cnt_q;
            if (wr_ie)                  ie_q   <= bus_wdata[N_MATCH-1:0];
            if (wr_wden)                wden_q <= bus_wdata[0];
        end
    end

    mtw_match_bank #(.N(N_MATCH), .CNT_W(CNT_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_nxt(cnt_nxt),
        .mwr    (mwr),
        .wdata  (bus_wdata[CNT_W-1:0]),
        .sts_clr(sts_clr),
        .match  (match),
        .sts    (sts),
        .hit    (hit)
    );

    mtw_wd_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (hit[WD_CH] && ie_q[WD_CH] && wden_q),
        .rearm   (mwr[WD_CH]),
        .wdog_rst(wdog_rst)
    );

    assign irq = |(sts & ie_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_COUNT:   bus_rdata = DW'(cnt_q);
            OFS_STATUS:  bus_rdata = DW'(sts);
            OFS_INTEN:   bus_rdata = DW'(ie_q);
            OFS_WDEN:    bus_rdata = DW'(wden_q);
            OFS_SNAPVAL: bus_rdata = DW'(snap_q);
            default:     bus_rdata = '0;
        endcase
        for (int i = 0; i < N_MATCH; i++) begin
            if (bus_addr == AW'(OFS_MATCH0 + 4 * i)) bus_rdata = DW'(match[i]);
        end
    end
endmodule

// File: rtl/mtw_chk.sv
module mtw_chk #(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 6,
    parameter int WD_CH   = 5,
    parameter int DIV     = 50,
    parameter int RST_CYC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [CNT_W-1:0]   cnt,
    input logic [N_MATCH-1:0] sts,
    input logic [N_MATCH-1:0] ie,
    input logic               wden,
    input logic               sts_wr,
    input logic               wdog_rst
);
    localparam int RW = $clog2(RST_CYC + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (wdog_rst) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    generate
        if (DIV > 1) begin : g_gap
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

    p_sts_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts & $past(sts)) == $past(sts)));

    p_fire_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> $past(ie[WD_CH] && wden));

    p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (run_q < RW'(RST_CYC)));
endmodule

bind mtimer_wdog mtw_chk #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .WD_CH(WD_CH), .DIV(DIV), .RST_CYC(RST_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q), .sts(sts), .ie(ie_q),
    .wden(wden_q), .sts_wr(wr_sts), .wdog_rst(wdog_rst)
);

// File: tb/sim_mtimer_wdog.sv
module sim_mtimer_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 12;
    localparam int NCH = 6;
    localparam int WDC = 5;
    localparam int DIVV = 2;
    localparam int RSTC = 4;
    localparam int MOD = 1 << CNT_W;

    localparam logic [7:0] A_CNT = 8'h00, A_M0 = 8'h08, A_STS = 8'h20, A_IE = 8'h24,
                           A_WDEN = 8'h28, A_SNAP = 8'h30, A_SNAPV = 8'h34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, wdog_rst;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mtimer_wdog #(.CLK_HZ(2), .TICK_HZ(1), .CNT_W(CNT_W), .N_MATCH(NCH),
                  .WD_CH(WDC), .RST_CYC(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic arm(input int ch, input int d, output logic [31:0] m);
        logic [31:0] l;
        wr(A_SNAP, 32'h1);
        rd(A_SNAPV, l);
        m = (l + d) % MOD;
        wr(A_M0 + 8'(4 * ch), m);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c, l1, l2, m;
        int n, hi;
        int dl[5] = '{3, 4, 5, 9, 17};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CNT, v);   chk(v == 0, "R1 counter", v, 0);
        rd(A_STS, v);   chk(v == 0, "R1 status", v, 0);
        rd(A_IE, v);    chk(v == 0, "R1 inten", v, 0);
        rd(A_WDEN, v);  chk(v == 0, "R1 wden", v, 0);
        rd(A_SNAPV, v); chk(v == 0, "R1 snapshot", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(A_M0 + 8'(4 * i), v); chk(v == 0, "R1 match", v, 0);
        end
        chk(!irq && !wdog_rst, "R1 outputs", {30'b0, irq, wdog_rst}, 0);

        // R10 holes
        rd(8'h04, v); chk(v == 0, "R10 0x04", v, 0);
        rd(8'h2C, v); chk(v == 0, "R10 0x2C", v, 0);
        rd(8'h38, v); chk(v == 0, "R10 0x38", v, 0);
        rd(8'h3C, v); chk(v == 0, "R10 0x3C", v, 0);

        // R2 count rate, sampled at exact multiples of DIV cycles
        @(negedge clk);
        rd(A_CNT, l1);
        for (int k = 1; k <= 4; k++) begin
            repeat (DIVV * 7) @(negedge clk);
            rd(A_CNT, c);
            chk(c == (l1 + 7 * k) % MOD, "R2 rate", c, (l1 + 7 * k) % MOD);
        end
        wr(A_CNT, 32'h5A5);
        rd(A_CNT, c);
        chk(c != 32'h5A5 || l1 + 29 == 32'h5A5, "R2 write ignored", c, 0);

        // R4 snapshot
        wr(A_SNAP, 32'h1);
        repeat (DIVV * 10 - 1) @(negedge clk);
        wr(A_SNAP, 32'h1);
        rd(A_SNAPV, l2);
        // first snapshot lost, recompute with exact spacing
        wr(A_SNAP, 32'h1);
        rd(A_SNAPV, l1);
        repeat (DIVV * 10 - 1) @(negedge clk);
        wr(A_SNAP, 32'h1);
        rd(A_SNAPV, l2);
        chk(l2 == (l1 + 10) % MOD, "R4 spacing", l2, (l1 + 10) % MOD);
        repeat (9) @(negedge clk);
        rd(A_SNAPV, v); chk(v == l2, "R4 hold", v, l2);
        wr(A_SNAP, 32'h0);
        repeat (6) @(negedge clk);
        rd(A_SNAPV, v); chk(v == l2, "R4 bit0 clear ignored", v, l2);

        // R5/R6/R7 sweep over channels and distances (wden off)
        wr(A_WDEN, 32'h0);
        for (int ch = 0; ch < NCH; ch++) begin
            for (int di = 0; di < 5; di++) begin
                wr(A_STS, 32'h3F);
                wr(A_IE, 32'(1 << ch));
                arm(ch, dl[di], m);
                n = 0; hi = 0;
                while (!irq && n < 200) begin
                    @(negedge clk); n++;
                    if (wdog_rst) hi++;
                end
                rd(A_CNT, c);
                chk(irq && c == m, "R5 counter at match", c, m);
                rd(A_STS, v);
                chk(v[ch], "R5 status bit", v, 32'(1 << ch));
                chk(hi == 0 && !wdog_rst, "R7 no reset without wden", hi, 0);
                if (di == 0) begin
                    wr(A_STS, 32'h0);
                    rd(A_STS, v);
                    chk(v[ch] && irq, "R6 write 0 keeps", v, 32'(1 << ch));
                end
                wr(A_STS, 32'(1 << ch));
                rd(A_STS, v);
                chk(!v[ch] && !irq, "R6 w1c clears", v, 0);
            end
        end

        // R6 status without enable
        wr(A_STS, 32'h3F);
        wr(A_IE, 32'h0);
        arm(1, 6, m);
        repeat (20) @(negedge clk);
        rd(A_STS, v);
        chk(v[1] && !irq, "R6 masked channel", {v[30:0], irq}, 32'h4);

        // R7/R8 watchdog fire
        wr(A_STS, 32'h3F);
        wr(A_IE, 32'(1 << WDC));
        wr(A_WDEN, 32'h1);
        arm(WDC, 10, m);
        n = 0;
        while (!wdog_rst && n < 200) begin @(negedge clk); n++; end
        rd(A_CNT, c);
        chk(wdog_rst && c == m, "R7 fires at match", c, m);
        rd(A_STS, v);
        chk(v[WDC] && irq, "R8 same edge as status", v, 32'(1 << WDC));
        hi = 0;
        while (wdog_rst && hi < 100) begin hi++; @(negedge clk); end
        chk(hi == RSTC, "R8 pulse length", hi, RSTC);

        // R9 no refire across a full lap
        hi = 0;
        repeat (MOD * DIVV + 200) begin
            @(negedge clk);
            if (wdog_rst) hi++;
        end
        chk(hi == 0, "R9 one shot", hi, 0);

        // R9 rewrite re-arms
        arm(WDC, 10, m);
        n = 0;
        while (!wdog_rst && n < 200) begin @(negedge clk); n++; end
        rd(A_CNT, c);
        chk(wdog_rst && c == m, "R9 refire after rewrite", c, m);
        repeat (RSTC + 2) @(negedge clk);

        // R7 ie bit clear, wden set
        wr(A_STS, 32'h3F);
        wr(A_IE, 32'h0);
        arm(WDC, 8, m);
        hi = 0;
        repeat (40) begin @(negedge clk); if (wdog_rst) hi++; end
        rd(A_STS, v);
        chk(hi == 0 && v[WDC], "R7 no reset without inten", hi, 0);

        // R7 disarm after arming
        wr(A_STS, 32'h3F);
        wr(A_IE, 32'(1 << WDC));
        arm(WDC, 30, m);
        wr(A_WDEN, 32'h0);
        hi = 0;
        repeat (90) begin @(negedge clk); if (wdog_rst) hi++; end
        rd(A_STS, v);
        chk(hi == 0 && v[WDC] && irq, "R7 disarm", hi, 0);

        // R3 wrap: snapshot spacing across the wrap and a match past it
        wr(A_SNAP, 32'h1);
        rd(A_SNAPV, l1);
        repeat (DIVV * 3000 - 1) @(negedge clk);
        wr(A_SNAP, 32'h1);
        rd(A_SNAPV, l2);
        chk(l2 == (l1 + 3000) % MOD, "R3 wrap spacing", l2, (l1 + 3000) % MOD);
        n = 0;
        rd(A_CNT, c);
        while (c < MOD - 16 && n < MOD * DIVV + 10) begin
            @(negedge clk); n++;
            rd(A_CNT, c);
        end
        wr(A_STS, 32'h3F);
        wr(A_IE, 32'h1);
        arm(0, 40, m);
        n = 0;
        while (!irq && n < 300) begin @(negedge clk); n++; end
        rd(A_CNT, c);
        chk(irq && c == m && m < 40, "R3 match past wrap", c, m);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule